// File: doc/BRIEF.md
# Handshaked Byte-Link Transaction Controller

This block sequences a half-duplex, byte-serial link between a host and a peripheral microcontroller. The bytes move through an external shift register. The controller drives three link lines: the shift direction, a transfer-in-progress line (TIP) and an acknowledge line. It reacts to two inputs: an active-high request line from the peripheral and a one-cycle byte-complete pulse from the shifter.

An outbound packet is sent from a buffer outside the block. The block presents a byte index, and the buffer answers with that byte in the same cycle. Inbound frames are collected into an internal buffer that has a read port. When a frame ends, the block reports the frame's type byte and its payload length with a one-cycle strobe.

A collision happens when the peripheral raises its request while a send is in progress. The block then gives up the link, receives the peripheral's frame, and retries the whole packet from byte 0. All waits come from parameters given in microseconds and are counted with a clocks-per-microsecond parameter.

The states and their transitions are these:
- NOT_READY goes to IDLE once `link_en` is seen.
- IDLE goes to WAIT_TX when a send is pending.
- WAIT_TX goes to OUT when the short wait expires with the request inactive. If the request is active at that point, it goes back to IDLE.
- OUT stays in OUT while bytes remain. It goes to IDLE when the last byte completes. It goes to RECOVER on a collision.
- RECOVER goes to IN when the short wait expires with the request active. Otherwise it goes to IDLE.
- IN goes to IDLE or to HOLDOFF when the frame ends.
- HOLDOFF goes to OUT when the long wait expires with the request inactive. If the request is active at that point, it goes back to IDLE.
- IDLE, WAIT_TX and HOLDOFF all go to IN when a byte completes while the request is active.

Top module: `bytelink_ctrl`

## Requirements
- R1: After reset the block is in NOT_READY with `tip`=0, `dir_out`=0 (input) and `ack`=1. In NOT_READY, byte-complete pulses have no effect, and every send request is answered with `send_busy`. Seeing `link_en`=1 moves the block to IDLE.
- R2: A send request is answered in the following cycle. The answer is `send_accept` when no send is pending and `send_len` is nonzero. Otherwise the answer is `send_busy`. The two answers are never given together.
- R3: A request accepted in IDLE asserts `tip` exactly SHORT_US*CLK_PER_US+1 cycles after the accepting edge, provided `periph_req` is low when the wait ends. If `periph_req` is high at that point, `tip` stays low and the block keeps polling until the line drops.
- R4: A send starts in a single cycle. In that cycle `dir_out`=1, `sr_load`=1, `sr_wdata` holds byte index 0, `ack`=0 and `tip`=1.
- R5: In OUT, a byte-complete pulse with `periph_req` low has one of two effects. If the count of sent bytes now equals `send_len`, the block releases `tip`, sets `dir_out`=0 and `ack`=1, and clears the pending send. Otherwise it loads byte index n (the count so far) and toggles `ack`.
- R6: In OUT, a byte-complete pulse with `periph_req` high aborts the send at that edge: `tip`=0, `dir_out`=0, `ack`=1, and the send stays pending. SHORT_US*CLK_PER_US cycles later the block enters IN (`tip`=1) if the request is still high.
- R7: In IDLE, a byte-complete pulse with `periph_req` high enters IN with `tip`=1 and `dir_out`=0. That first byte is a lead byte and is discarded. With `periph_req` low, the pulse is a false start and `tip` stays low.
- R8: In IN, the first byte after the lead byte is the type byte. Later bytes are payload, stored at buffer addresses 0, 1, 2 and so on. Each byte that arrives with `periph_req` high toggles `ack`. A byte that arrives with `periph_req` low ends the frame.
- R9: At frame end, `frame_done` is high for one cycle together with `frame_type` and `frame_len`. `frame_len` equals the received count (lead byte included) minus two. In that same cycle `tip`=0 and `ack`=1.
- R10: When the payload reaches BUF_DEPTH bytes, the frame ends even if `periph_req` is high. `frame_ovf`=1 is reported and `frame_len`=BUF_DEPTH.
- R11: A frame that ends while a send is pending starts a wait of LONG_US*CLK_PER_US cycles. When the wait ends, the send starts from byte 0 if `periph_req` is low. If `periph_req` is high, the send is backed out and the next byte-complete pulse starts a receive.
- R12: `ack` is high whenever `tip` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_en | input | 1 | Leaves NOT_READY when high |
| send_req | input | 1 | One-cycle request to send a packet |
| send_len | input | 8 | Packet length in bytes (1..255) |
| send_accept | output | 1 | Request taken (pulse) |
| send_busy | output | 1 | Request refused (pulse) |
| tx_idx | output | 8 | Index of the packet byte wanted this cycle |
| tx_byte | input | 8 | Packet byte at `tx_idx`, combinational |
| sr_load | output | 1 | Load `sr_wdata` into the shifter |
| sr_wdata | output | 8 | Byte to shift out |
| sr_rdata | input | 8 | Byte last shifted in |
| byte_done | input | 1 | Shifter finished one byte |
| periph_req | input | 1 | Peripheral request line, active high |
| dir_out | output | 1 | Shift direction, 1 = host to peripheral |
| tip | output | 1 | Transfer in progress |
| ack | output | 1 | Acknowledge line |
| frame_done | output | 1 | Inbound frame finished (pulse) |
| frame_type | output | 8 | Type byte of the finished frame |
| frame_len | output | $clog2(BUF_DEPTH+1) | Payload length of the finished frame |
| frame_ovf | output | 1 | Frame was cut at buffer capacity |
| rd_addr | input | $clog2(BUF_DEPTH) | Payload buffer read address |
| rd_data | output | 8 | Payload byte at `rd_addr` |

## Verification
The bench sweeps packet lengths 1 to 5 and every inbound payload length from empty up to one short of capacity. This catches an off-by-one in the sent-count compare, which would send one byte too many or stop one short. It also catches an error in the length arithmetic or the payload address, which would misreport the length or shift the stored data by one slot.

A collision is forced mid-packet, and the hold-off window is then crossed with the request both high and low. A design that failed to keep the send pending, or that restarted from the wrong index, would lose the packet or resend a tail. A design that ignored the request at the end of the hold-off would drive the line against the peripheral.

Exact cycle counts are checked at the pre-send wait, the recovery wait and the hold-off wait, so a wait that is one cycle short or long shows up. A frame is also filled to capacity while the request stays high, which shows whether the frame is cut once with the overflow flag set.

// File: rtl/bytelink_pkg.sv
package bytelink_pkg;
    typedef enum logic [2:0] {
        ST_NOT_READY = 3'd0,
        ST_IDLE      = 3'd1,
        ST_WAIT_TX   = 3'd2,
        ST_OUT       = 3'd3,
        ST_RECOVER   = 3'd4,
        ST_IN        = 3'd5,
        ST_HOLDOFF   = 3'd6
    } link_state_t;
endpackage

// File: rtl/link_delay_timer.sv
module link_delay_timer #(
    parameter int SHORT_CYC = 7500,
    parameter int LONG_CYC  = 75000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sel_long,
    output logic done
);
    localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int W    = $clog2(MAXC + 1);
    localparam logic [W-1:0] SHORT_LD = W'(SHORT_CYC - 1);
    localparam logic [W-1:0] LONG_LD  = W'(LONG_CYC - 1);

    logic [W-1:0] cnt;
    logic         run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= sel_long ? LONG_LD : SHORT_LD;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/link_rx_buffer.sv
module link_rx_buffer #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bytelink_ctrl.sv
module bytelink_ctrl #(
    parameter int CLK_PER_US = 50,
    parameter int SHORT_US   = 150,
    parameter int LONG_US    = 1500,
    parameter int BUF_DEPTH  = 256
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           link_en,
    input  logic                           send_req,
    input  logic [7:0]                     send_len,
    output logic                           send_accept,
    output logic                           send_busy,
    output logic [7:0]                     tx_idx,
    input  logic [7:0]                     tx_byte,
    output logic                           sr_load,
    output logic [7:0]                     sr_wdata,
    input  logic [7:0]                     sr_rdata,
    input  logic                           byte_done,
    input  logic                           periph_req,
    output logic                           dir_out,
    output logic                           tip,
    output logic                           ack,
    output logic                           frame_done,
    output logic [7:0]                     frame_type,
    output logic [$clog2(BUF_DEPTH+1)-1:0] frame_len,
    output logic                           frame_ovf,
    input  logic [$clog2(BUF_DEPTH)-1:0]   rd_addr,
    output logic [7:0]                     rd_data
);
    import bytelink_pkg::*;

    localparam int LEN_W     = $clog2(BUF_DEPTH + 1);
    localparam int CNT_W     = $clog2(BUF_DEPTH + 3);
    localparam int ADDR_W    = $clog2(BUF_DEPTH);
    localparam int SHORT_CYC = SHORT_US * CLK_PER_US;
    localparam int LONG_CYC  = LONG_US * CLK_PER_US;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BUF_DEPTH + 1);

    link_state_t      state, nxt;
    logic             pend;
    logic [7:0]       tx_len;
    logic [7:0]       sent;
    logic [CNT_W-1:0] rx_cnt;
    logic [7:0]       type_r;

    logic accept, tmr_start, tmr_long, tmr_done;
    logic go_send, do_abort, do_enter_in, do_tx_next, do_tx_done, do_rx, rx_last;
    logic last_out, rx_full, buf_we;

    assign accept   = send_req && (state != ST_NOT_READY) && !pend && (send_len != 8'd0);
    assign last_out = ({1'b0, sent} + 9'd1) == {1'b0, tx_len};
    assign rx_full  = (rx_cnt == FULL_CNT);
    assign tx_idx   = (state == ST_OUT) ? (sent + 8'd1) : 8'd0;
    assign buf_we   = do_rx && (rx_cnt >= CNT_W'(2));

    link_delay_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .sel_long(tmr_long), .done(tmr_done)
    );

    link_rx_buffer #(.DEPTH(BUF_DEPTH), .AW(ADDR_W)) u_rxbuf (
        .clk(clk), .we(buf_we), .waddr(ADDR_W'(rx_cnt - CNT_W'(2))),
        .wdata(sr_rdata), .raddr(rd_addr), .rdata(rd_data)
    );

    // next-state and action decode
    always_comb begin
        nxt = state;
        go_send = 1'b0; do_abort = 1'b0; do_enter_in = 1'b0;
        do_tx_next = 1'b0; do_tx_done = 1'b0; do_rx = 1'b0; rx_last = 1'b0;
        tmr_start = 1'b0; tmr_long = 1'b0;
        unique case (state)
            ST_NOT_READY: if (link_en) nxt = ST_IDLE;
            ST_IDLE, ST_WAIT_TX, ST_HOLDOFF: begin
                if (byte_done) begin
                    // lead byte of an inbound frame, or a false start
                    if (periph_req) begin do_enter_in = 1'b1; nxt = ST_IN; end
                    else nxt = ST_IDLE;
                end else if (state == ST_IDLE) begin
                    if (pend) begin nxt = ST_WAIT_TX; tmr_start = 1'b1; end
                end else if (tmr_done) begin
                    if (periph_req) nxt = ST_IDLE;
                    else begin go_send = 1'b1; nxt = ST_OUT; end
                end
            end
            ST_OUT: if (byte_done) begin
                if (periph_req) begin do_abort = 1'b1; nxt = ST_RECOVER; tmr_start = 1'b1; end
                else if (last_out) begin do_tx_done = 1'b1; nxt = ST_IDLE; end
                else do_tx_next = 1'b1;
            end
            ST_RECOVER: if (tmr_done) begin
                if (periph_req) begin do_enter_in = 1'b1; nxt = ST_IN; end
                else nxt = ST_IDLE;
            end
            ST_IN: if (byte_done) begin
                do_rx = 1'b1;
                if (!periph_req || rx_full) begin
                    rx_last = 1'b1;
                    if (pend) begin nxt = ST_HOLDOFF; tmr_start = 1'b1; tmr_long = 1'b1; end
                    else nxt = ST_IDLE;
                end
            end
            default: nxt = ST_NOT_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_NOT_READY;
        else        state <= nxt;
    end

    // link lines and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_out <= 1'b0; tip <= 1'b0; ack <= 1'b1;
            sr_load <= 1'b0; sr_wdata <= 8'd0;
            pend <= 1'b0; tx_len <= 8'd0; sent <= 8'd0;
            rx_cnt <= '0; type_r <= 8'd0;
            send_accept <= 1'b0; send_busy <= 1'b0;
            frame_done <= 1'b0; frame_type <= 8'd0; frame_len <= '0; frame_ovf <= 1'b0;
        end else begin
            sr_load     <= 1'b0;
            frame_done  <= 1'b0;
            frame_ovf   <= 1'b0;
            send_accept <= accept;
            send_busy   <= send_req && !accept;
            if (accept) begin
                pend   <= 1'b1;
                tx_len <= send_len;
            end
            if (go_send) begin
                dir_out <= 1'b1; sr_load <= 1'b1; sr_wdata <= tx_byte;
                ack <= 1'b0; tip <= 1'b1; sent <= 8'd0;
            end
            if (do_abort) begin
                dir_out <= 1'b0; tip <= 1'b0; ack <= 1'b1; sent <= 8'd0;
            end
            if (do_tx_done) begin
                dir_out <= 1'b0; tip <= 1'b0; ack <= 1'b1; pend <= 1'b0;
            end
            if (do_tx_next) begin
                sent <= sent + 8'd1; sr_load <= 1'b1; sr_wdata <= tx_byte; ack <= ~ack;
            end
            if (do_enter_in) begin
                dir_out <= 1'b0; tip <= 1'b1; rx_cnt <= CNT_W'(1);
            end
            if (do_rx) begin
                rx_cnt <= rx_cnt + 1'b1;
                if (rx_cnt == CNT_W'(1)) type_r <= sr_rdata;
                if (rx_last) begin
                    tip <= 1'b0; ack <= 1'b1; frame_done <= 1'b1;
                    frame_type <= (rx_cnt == CNT_W'(1)) ? sr_rdata : type_r;
                    frame_len  <= LEN_W'(rx_cnt - CNT_W'(1));
                    frame_ovf  <= rx_full;
                end else begin
                    ack <= ~ack;
                end
            end
        end
    end
endmodule

// File: rtl/bytelink_ctrl_chk.sv
module bytelink_ctrl_chk #(
    parameter int BUF_DEPTH = 256,
    parameter int LEN_W     = 9
) (
    input logic                       clk,
    input logic                       rst_n,
    input bytelink_pkg::link_state_t  state,
    input logic                       tip,
    input logic                       ack,
    input logic                       dir_out,
    input logic                       sr_load,
    input logic                       send_accept,
    input logic                       send_busy,
    input logic                       frame_done,
    input logic [LEN_W-1:0]           frame_len,
    input logic                       frame_ovf
);
    import bytelink_pkg::*;

    p_ack_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tip |-> ack);

    p_load_outward_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load |-> (dir_out && tip));

    p_resp_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_accept && send_busy));

    p_not_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NOT_READY) |-> (!tip && !dir_out && !send_accept));

    p_frame_end_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!tip && ack && frame_len <= LEN_W'(BUF_DEPTH)));

    p_ovf_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ovf |-> (frame_done && frame_len == LEN_W'(BUF_DEPTH)));

    p_abort_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER) |-> (!tip && !dir_out));
endmodule

bind bytelink_ctrl bytelink_ctrl_chk #(.BUF_DEPTH(BUF_DEPTH), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .tip(tip), .ack(ack), .dir_out(dir_out),
    .sr_load(sr_load), .send_accept(send_accept), .send_busy(send_busy),
    .frame_done(frame_done), .frame_len(frame_len), .frame_ovf(frame_ovf)
);

// File: tb/bytelink_ctrl_test.sv
module bytelink_ctrl_test;
    localparam int CPU   = 2;
    localparam int SUS   = 3;
    localparam int LUS   = 5;
    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);
    localparam int AW    = $clog2(DEPTH);
    localparam int SHORT = SUS * CPU;
    localparam int LONG  = LUS * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_en = 1'b0, send_req = 1'b0, byte_done = 1'b0, periph_req = 1'b0;
    logic [7:0] send_len = 8'd0, sr_rdata = 8'd0;
    logic [7:0] tx_idx, tx_byte, sr_wdata, frame_type, rd_data;
    logic send_accept, send_busy, sr_load, dir_out, tip, ack, frame_done, frame_ovf;
    logic [LW-1:0] frame_len;
    logic [AW-1:0] rd_addr = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] txv(input int i);
        return 8'((i * 7 + 17) & 255);
    endfunction

    function automatic logic [7:0] pdat(input int k, input int j);
        return 8'((k * 16 + j * 3 + 5) & 255);
    endfunction

    assign tx_byte = txv(int'(tx_idx));

    bytelink_ctrl #(.CLK_PER_US(CPU), .SHORT_US(SUS), .LONG_US(LUS), .BUF_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .send_req(send_req), .send_len(send_len),
        .send_accept(send_accept), .send_busy(send_busy), .tx_idx(tx_idx), .tx_byte(tx_byte),
        .sr_load(sr_load), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .byte_done(byte_done),
        .periph_req(periph_req), .dir_out(dir_out), .tip(tip), .ack(ack),
        .frame_done(frame_done), .frame_type(frame_type), .frame_len(frame_len),
        .frame_ovf(frame_ovf), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic req_send(input int len);
        @(negedge clk);
        send_req = 1'b1; send_len = 8'(len);
        @(negedge clk);
        send_req = 1'b0;
    endtask

    task automatic pulse_byte(input logic [7:0] d, input logic rq);
        @(negedge clk);
        byte_done = 1'b1; sr_rdata = d; periph_req = rq;
        @(negedge clk);
        byte_done = 1'b0;
    endtask

    task automatic wait_tip(input int lim);
        for (int i = 0; i < lim && !tip; i++) @(negedge clk);
    endtask

    // send bytes 1..len-1 then finish; assumes the start cycle was just observed
    task automatic finish_send(input string tag, input int len);
        for (int i = 1; i < len; i++) begin
            pulse_byte(8'h00, 1'b0);
            chk({tag, " R5 next load"}, int'(sr_load), 1);
            chk({tag, " R5 next byte"}, int'(sr_wdata), int'(txv(i)));
            chk({tag, " R5 ack toggle"}, int'(ack), i % 2);
        end
        pulse_byte(8'h00, 1'b0);
        chk({tag, " R5 done tip"}, int'(tip), 0);
        chk({tag, " R5 done dir"}, int'(dir_out), 0);
        chk({tag, " R5 done ack"}, int'(ack), 1);
        chk({tag, " R5 no extra load"}, int'(sr_load), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and NOT_READY behaviour
        chk("R1 reset tip", int'(tip), 0);
        chk("R1 reset dir", int'(dir_out), 0);
        chk("R1 reset ack", int'(ack), 1);
        req_send(2);
        chk("R1 refused busy", int'(send_busy), 1);
        chk("R1 refused accept", int'(send_accept), 0);
        pulse_byte(8'h33, 1'b1);
        chk("R1 byte ignored tip", int'(tip), 0);
        periph_req = 1'b0;
        @(negedge clk);
        chk("R1 byte ignored frame", int'(frame_done), 0);
        link_en = 1'b1;
        repeat (2) @(negedge clk);

        // R7 false start in IDLE
        pulse_byte(8'h44, 1'b0);
        chk("R7 false start tip", int'(tip), 0);
        @(negedge clk);
        chk("R7 false start no frame", int'(frame_done), 0);

        // R2 zero length refused
        req_send(0);
        chk("R2 zero length busy", int'(send_busy), 1);

        // sweep of packet lengths: R2 R3 R4 R5
        for (int len = 1; len <= 5; len++) begin
            req_send(len);
            chk("R2 accept", int'(send_accept), 1);
            chk("R2 not busy", int'(send_busy), 0);
            repeat (SHORT) @(negedge clk);
            chk("R3 wait tip low", int'(tip), 0);
            @(negedge clk);
            chk("R3 tip rise", int'(tip), 1);
            chk("R4 dir out", int'(dir_out), 1);
            chk("R4 ack low", int'(ack), 0);
            chk("R4 load", int'(sr_load), 1);
            chk("R4 byte0", int'(sr_wdata), int'(txv(0)));
            if (len == 3) begin
                req_send(2);
                chk("R2 pending busy", int'(send_busy), 1);
                chk("R2 pending no accept", int'(send_accept), 0);
            end
            finish_send("sweep", len);
        end

        // R3 request active when the wait ends
        periph_req = 1'b1;
        req_send(1);
        repeat (SHORT + 1) @(negedge clk);
        chk("R3 held off by request", int'(tip), 0);
        periph_req = 1'b0;
        wait_tip(40);
        chk("R3 starts after request drops", int'(tip), 1);
        chk("R3 byte0", int'(sr_wdata), int'(txv(0)));
        finish_send("R3", 1);

        // inbound sweep over payload lengths: R7 R8 R9
        for (int k = 0; k < DEPTH; k++) begin
            periph_req = 1'b1;
            pulse_byte(8'hEE, 1'b1);
            chk("R7 enter in tip", int'(tip), 1);
            chk("R7 enter in dir", int'(dir_out), 0);
            chk("R8 ack before type", int'(ack), 1);
            pulse_byte(8'(k + 8'h40), k > 0);
            if (k > 0) chk("R8 ack toggled on type", int'(ack), 0);
            for (int j = 0; j < k; j++) pulse_byte(pdat(k, j), j < k - 1);
            chk("R9 frame done", int'(frame_done), 1);
            chk("R9 type", int'(frame_type), k + 8'h40);
            chk("R9 length", int'(frame_len), k);
            chk("R9 tip released", int'(tip), 0);
            chk("R10 no overflow", int'(frame_ovf), 0);
            periph_req = 1'b0;
            @(negedge clk);
            chk("R9 strobe one cycle", int'(frame_done), 0);
            for (int j = 0; j < k; j++) begin
                rd_addr = AW'(j);
                #1;
                chk("R8 payload", int'(rd_data), int'(pdat(k, j)));
            end
        end

        // R10 overflow with request held high
        periph_req = 1'b1;
        pulse_byte(8'hEE, 1'b1);
        pulse_byte(8'h5C, 1'b1);
        for (int j = 0; j < DEPTH; j++) pulse_byte(pdat(9, j), 1'b1);
        chk("R10 frame cut", int'(frame_done), 1);
        chk("R10 overflow flag", int'(frame_ovf), 1);
        chk("R10 length", int'(frame_len), DEPTH);
        chk("R10 tip released", int'(tip), 0);
        rd_addr = AW'(DEPTH - 1);
        #1;
        chk("R10 last stored", int'(rd_data), int'(pdat(9, DEPTH - 1)));
        periph_req = 1'b0;
        repeat (2) @(negedge clk);

        // R6 collision, R11 hold-off back-out and retry
        req_send(4);
        wait_tip(40);
        chk("R6 send started", int'(tip), 1);
        pulse_byte(8'h00, 1'b0);
        chk("R6 byte1 loaded", int'(sr_wdata), int'(txv(1)));
        pulse_byte(8'hEE, 1'b1);
        chk("R6 abort tip", int'(tip), 0);
        chk("R6 abort dir", int'(dir_out), 0);
        chk("R6 abort ack", int'(ack), 1);
        repeat (SHORT - 1) @(negedge clk);
        chk("R6 recover wait", int'(tip), 0);
        @(negedge clk);
        chk("R6 enters receive", int'(tip), 1);
        chk("R6 receive dir", int'(dir_out), 0);
        pulse_byte(8'h77, 1'b1);
        pulse_byte(8'hA1, 1'b0);
        chk("R6 frame len", int'(frame_len), 1);
        chk("R6 frame type", int'(frame_type), 8'h77);
        periph_req = 1'b1;
        repeat (LONG) @(negedge clk);
        chk("R11 backed out", int'(tip), 0);
        chk("R11 backed out dir", int'(dir_out), 0);
        pulse_byte(8'hEE, 1'b1);
        chk("R11 second receive", int'(tip), 1);
        pulse_byte(8'h78, 1'b0);
        chk("R11 second frame len", int'(frame_len), 0);
        repeat (LONG - 1) @(negedge clk);
        chk("R11 holdoff tip low", int'(tip), 0);
        @(negedge clk);
        chk("R11 retry tip", int'(tip), 1);
        chk("R11 retry byte0", int'(sr_wdata), int'(txv(0)));
        chk("R11 retry dir", int'(dir_out), 1);
        finish_send("R11", 4);
        req_send(1);
        chk("R5 pending cleared", int'(send_accept), 1);
        wait_tip(40);
        finish_send("tail", 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule